// File: doc/BRIEF.md
# Trigger and PWM Range Pin Controller

This block serves one bidirectional mode pin. A host can use that pin to start distance measurements and to read back the range without using a serial bus. The block synchronises and debounces the pin. When it sees a falling edge, it sends a single-cycle start strobe to the ranging core. When the core returns a distance in centimetres, the block drives the pin high for 10 µs per centimetre.

If the host still holds the pin low when a pulse ends, the block starts the next measurement without waiting for a new edge. The result is a free-running pulse train whose rate follows the distance. A status output gives the inverted, debounced pin level. It is frozen while the block drives the pin itself, so the block's own activity never shows in it. An optional busy indication pulls the pin low while an acquisition started over the serial bus is in progress.

The pin is modelled as three signals: a sampled input, a drive-high output and a drive-low enable. A parameterised divider produces the 10 µs tick from the system clock.

Top module: `mode_pin_ctrl`

## Requirements
- R1: The pin input reads 1 when released and 0 when pulled low. When the input falls and then stays low for DEB_TICKS consecutive ticks while the block is idle, the block asserts `meas_start` exactly once. A low glitch shorter than one tick period starts nothing.
- R2: When `meas_done` arrives with a non-zero `meas_dist`, `pin_drive_hi` rises in the next cycle. It stays high for exactly `meas_dist` × TICK_DIV clock cycles.
- R3: When `meas_done` arrives with `meas_dist` equal to 0, no pulse is produced. The block returns to idle and starts no further measurement, even if the pin is still held low.
- R4: If the pin is still low when a pulse ends, a new `meas_start` follows without a new falling edge. If the pin has been released, no new measurement starts.
- R5: A falling edge that arrives while a measurement is pending or a pulse is running is ignored. No extra `meas_start` results from it, either then or afterwards.
- R6: `pin_status` equals the inverted debounced pin level (1 means held low). It does not change while the block itself drives the pin high or low.
- R7: While `busy_mode_en` and `bus_acq_active` are both 1 and no pulse is running, `pin_drive_lo_en` is 1. Otherwise it is 0. It is never 1 together with `pin_drive_hi`. The block's own low drive never counts as a trigger.
- R8: After reset, `pin_drive_hi`, `pin_drive_lo_en`, `meas_start` and `pin_status` are all 0.
- R9: `meas_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Sampled level of the mode pin |
| pin_drive_hi | output | 1 | Drive the pin high (range pulse) |
| pin_drive_lo_en | output | 1 | Pull the pin low (busy indication) |
| busy_mode_en | input | 1 | Enables the busy indication on the pin |
| bus_acq_active | input | 1 | An acquisition started over the serial bus is running |
| meas_start | output | 1 | One-cycle request to the ranging core |
| meas_done | input | 1 | One-cycle result-valid from the ranging core |
| meas_dist | input | 16 | Measured distance in centimetres |
| pin_status | output | 1 | Inverted debounced pin level, masked during own drive |

## Verification
The host pulling the pin low and the block's own busy drive can overlap. Both make the pin read low in the same cycles. The bench provokes this by raising the serial-bus acquisition flag and the host's low level on the same clock. It then checks that no measurement starts while the block is driving. After the busy flag drops, it checks that exactly one measurement starts, because the host is still holding the pin low. The same masking is exercised a second way: the host keeps the pin low through a range pulse, and `pin_status` must stay steady throughout.

// File: rtl/mode_pin_pkg.sv
package mode_pin_pkg;

    localparam int DIST_W    = 16;
    localparam int MASK_TAIL = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_PULSE,
        ST_HOLD
    } fsm_st_t;

    typedef struct packed {
        logic hi;
        logic lo_en;
    } pin_drv_t;

    function automatic logic any_drive(input pin_drv_t d);
        return d.hi | d.lo_en;
    endfunction

endpackage

// File: rtl/mode_pin_tick.sv
module mode_pin_tick #(
    parameter int DIV = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/mode_pin_debounce.sv
module mode_pin_debounce #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic tick,
    input  logic mask,
    output logic lvl_sync,
    output logic level,
    output logic fall
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [1:0]    sy;
    logic [CW-1:0] cnt;
    logic          level_d;

    assign lvl_sync = sy[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sy      <= 2'b11;
            cnt     <= '0;
            level   <= 1'b1;
            level_d <= 1'b1;
        end else begin
            sy      <= {sy[0], pin_in};
            level_d <= level;
            if (mask || (lvl_sync == level)) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    level <= lvl_sync;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign fall = level_d & ~level;
endmodule

// File: rtl/mode_pin_fsm.sv
module mode_pin_fsm
    import mode_pin_pkg::*;
#(
    parameter int DW = DIST_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fall,
    input  logic          tick,
    input  logic          mask,
    input  logic          lvl_sync,
    input  logic          meas_done,
    input  logic [DW-1:0] meas_dist,
    output fsm_st_t       st,
    output logic          meas_start,
    output logic          drive_hi,
    output logic          tick_restart
);
    fsm_st_t       st_nx;
    logic [DW-1:0] cnt;
    logic          last_tick;

    assign last_tick = tick && (cnt <= DW'(1));

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (fall) st_nx = ST_START;
            ST_START: st_nx = ST_WAIT;
            ST_WAIT:  if (meas_done) st_nx = (meas_dist == '0) ? ST_IDLE : ST_PULSE;
            ST_PULSE: if (last_tick) st_nx = ST_HOLD;
            ST_HOLD:  if (!mask) st_nx = lvl_sync ? ST_IDLE : ST_START;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_WAIT && meas_done)   cnt <= meas_dist;
            else if (st == ST_PULSE && tick)  cnt <= cnt - 1'b1;
        end
    end

    assign meas_start   = (st == ST_START);
    assign drive_hi     = (st == ST_PULSE);
    assign tick_restart = (st == ST_WAIT) && meas_done;
endmodule

// File: rtl/mode_pin_ctrl.sv
module mode_pin_ctrl
    import mode_pin_pkg::*;
#(
    parameter int TICK_DIV  = 1250,
    parameter int DEB_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    output logic              pin_drive_hi,
    output logic              pin_drive_lo_en,
    input  logic              busy_mode_en,
    input  logic              bus_acq_active,
    output logic              meas_start,
    input  logic              meas_done,
    input  logic [DIST_W-1:0] meas_dist,
    output logic              pin_status
);
    logic tick, tick_restart, mask, lvl_sync, level, fall, hi;
    logic [MASK_TAIL-1:0] tail;
    pin_drv_t drv;
    fsm_st_t  fsm_st;

    assign drv.hi    = hi;
    assign drv.lo_en = busy_mode_en & bus_acq_active & ~hi;

    // Own drive plus a tail covering the synchroniser delay after release.
    always_ff @(posedge clk) begin
        if (rst) tail <= '0;
        else     tail <= {tail[MASK_TAIL-2:0], any_drive(drv)};
    end
    assign mask = any_drive(drv) | (|tail);

    mode_pin_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .restart(tick_restart), .tick(tick)
    );

    mode_pin_debounce #(.TICKS(DEB_TICKS)) u_deb (
        .clk(clk), .rst(rst), .pin_in(pin_in), .tick(tick), .mask(mask),
        .lvl_sync(lvl_sync), .level(level), .fall(fall)
    );

    mode_pin_fsm #(.DW(DIST_W)) u_fsm (
        .clk(clk), .rst(rst), .fall(fall), .tick(tick), .mask(mask),
        .lvl_sync(lvl_sync), .meas_done(meas_done), .meas_dist(meas_dist),
        .st(fsm_st), .meas_start(meas_start), .drive_hi(hi),
        .tick_restart(tick_restart)
    );

    assign pin_drive_hi    = drv.hi;
    assign pin_drive_lo_en = drv.lo_en;
    assign pin_status      = ~level;
endmodule

// File: rtl/mode_pin_ctrl_chk.sv
module mode_pin_ctrl_chk
    import mode_pin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              meas_start,
    input logic              meas_done,
    input logic [DIST_W-1:0] meas_dist,
    input logic              pin_drive_hi,
    input logic              pin_drive_lo_en,
    input logic              busy_mode_en,
    input logic              bus_acq_active,
    input logic              pin_status,
    input fsm_st_t           st
);
    p_strobe_one_r9: assert property (@(posedge clk) disable iff (rst)
        meas_start |=> !meas_start);

    p_no_fight_r7: assert property (@(posedge clk) disable iff (rst)
        !(pin_drive_hi && pin_drive_lo_en));

    p_busy_low_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_mode_en && bus_acq_active && !pin_drive_hi) |-> pin_drive_lo_en);

    p_busy_off_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy_mode_en && bus_acq_active) |-> !pin_drive_lo_en);

    p_zero_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && meas_done && meas_dist == '0) |=> (st == ST_IDLE && !pin_drive_hi));

    p_pulse_go_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && meas_done && meas_dist != '0) |=> pin_drive_hi);

    p_start_src_r5: assert property (@(posedge clk) disable iff (rst)
        meas_start |-> ($past(st) == ST_IDLE || $past(st) == ST_HOLD));

    p_status_masked_r6: assert property (@(posedge clk) disable iff (rst)
        pin_drive_hi |=> $stable(pin_status));
endmodule

bind mode_pin_ctrl mode_pin_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .meas_start(meas_start), .meas_done(meas_done),
    .meas_dist(meas_dist), .pin_drive_hi(pin_drive_hi),
    .pin_drive_lo_en(pin_drive_lo_en), .busy_mode_en(busy_mode_en),
    .bus_acq_active(bus_acq_active), .pin_status(pin_status), .st(fsm_st)
);

// File: tb/mode_pin_ctrl_tb.sv
module mode_pin_ctrl_tb;
    localparam int TDIV = 4;
    localparam int TDEB = 2;

    typedef struct packed {
        logic [15:0] d;
        logic        keep;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{16'd1,  1'b0}, '{16'd7, 1'b0}, '{16'd3, 1'b1},
        '{16'd12, 1'b0}, '{16'd2, 1'b1}, '{16'd5, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_low = 1'b0;
    logic busy_mode_en = 1'b0, bus_acq_active = 1'b0;
    logic meas_done = 1'b0;
    logic [15:0] meas_dist = '0;
    logic pin_in, pin_drive_hi, pin_drive_lo_en, meas_start, pin_status;

    int checks = 0, errors = 0;
    int starts = 0, npulses = 0, hi_run = 0, last_w = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign pin_in = pin_drive_hi ? 1'b1 : ((pin_drive_lo_en || host_low) ? 1'b0 : 1'b1);

    mode_pin_ctrl #(.TICK_DIV(TDIV), .DEB_TICKS(TDEB)) u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_drive_hi(pin_drive_hi),
        .pin_drive_lo_en(pin_drive_lo_en), .busy_mode_en(busy_mode_en),
        .bus_acq_active(bus_acq_active), .meas_start(meas_start),
        .meas_done(meas_done), .meas_dist(meas_dist), .pin_status(pin_status)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (meas_start) starts++;
            if (pin_drive_hi) hi_run++;
            else if (hi_run > 0) begin
                last_w = hi_run;
                npulses++;
                hi_run = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start(input int s0);
        for (int i = 0; i < 200 && starts == s0; i++) @(negedge clk);
    endtask

    task automatic core_reply(input int d);
        cyc(5);
        meas_dist = 16'(d);
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0, p0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R8 drive_hi", int'(pin_drive_hi), 0);
        chk("R8 drive_lo_en", int'(pin_drive_lo_en), 0);
        chk("R8 meas_start", int'(meas_start), 0);
        chk("R8 status", int'(pin_status), 0);
        cyc(20);

        for (int v = 0; v < NV; v++) begin
            s0 = starts; p0 = npulses;
            host_low = 1'b1;
            wait_start(s0);
            chk("R1 one start per edge", starts - s0, 1);
            core_reply(int'(VEC[v].d));
            if (!VEC[v].keep) host_low = 1'b0;
            cyc(2);
            chk("R6 status steady during pulse", int'(pin_status), 1);
            cyc(int'(VEC[v].d) * TDIV + 40);
            chk("R2 pulse width", last_w, int'(VEC[v].d) * TDIV);
            chk("R2 pulse count", npulses - p0, 1);
            chk("R4 auto repeat", starts - s0, VEC[v].keep ? 2 : 1);
            if (VEC[v].keep) core_reply(0);
            host_low = 1'b0;
            cyc(40);
            chk("R6 status released", int'(pin_status), 0);
        end

        // glitch shorter than a tick
        s0 = starts;
        host_low = 1'b1; cyc(1); host_low = 1'b0;
        cyc(40);
        chk("R1 glitch ignored", starts - s0, 0);

        // zero distance
        s0 = starts; p0 = npulses;
        host_low = 1'b1;
        wait_start(s0);
        core_reply(0);
        cyc(60);
        chk("R3 no pulse for zero", npulses - p0, 0);
        chk("R3 no restart for zero", starts - s0, 1);
        host_low = 1'b0; cyc(40);

        // edge during pending measurement
        s0 = starts;
        host_low = 1'b1;
        wait_start(s0);
        host_low = 1'b0; cyc(30);
        host_low = 1'b1; cyc(30);
        chk("R5 edge ignored while pending", starts - s0, 1);
        core_reply(0);
        cyc(40);
        chk("R5 no late start", starts - s0, 1);
        host_low = 1'b0; cyc(40);

        // busy indication
        s0 = starts;
        busy_mode_en = 1'b1; bus_acq_active = 1'b1;
        cyc(1);
        chk("R7 busy drives low", int'(pin_drive_lo_en), 1);
        cyc(40);
        chk("R7 own low no trigger", starts - s0, 0);
        chk("R6 status ignores own low", int'(pin_status), 0);
        bus_acq_active = 1'b0;
        cyc(1);
        chk("R7 busy released", int'(pin_drive_lo_en), 0);
        cyc(40);
        chk("R7 no start after busy", starts - s0, 0);
        busy_mode_en = 1'b0; bus_acq_active = 1'b1;
        cyc(1);
        chk("R7 busy disabled", int'(pin_drive_lo_en), 0);
        bus_acq_active = 1'b0;
        cyc(10);

        // host low and busy drive in the same cycle
        s0 = starts;
        busy_mode_en = 1'b1; bus_acq_active = 1'b1; host_low = 1'b1;
        cyc(40);
        chk("R7 no start while busy", starts - s0, 0);
        bus_acq_active = 1'b0;
        wait_start(s0);
        chk("R1 start after busy ends", starts - s0, 1);
        core_reply(0);
        host_low = 1'b0; busy_mode_en = 1'b0;
        cyc(40);
        chk("R1 single start after overlap", starts - s0, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule